// File: doc/BRIEF.md
# Watchdog Timer with Bus-Programmable Periods

This block is a watchdog for a system that must prove it is still alive. Software chooses a timeout from sixteen power-of-two periods, turns the counter on, and restarts it by writing a fixed magic byte. If software stops restarting it, the counter runs out. The block then either requests a system reset straight away or raises an interrupt first and resets only when a second timeout passes with no restart.

The block has a zero-wait-state APB slave with 8-bit offsets. Once the enable bit is set, software cannot clear it. Only the block's synchronous reset stops the counter. The first load after enabling uses its own period select, so a long boot window can be followed by a shorter run-time period. The exponent base is the parameter `BASE_EXP` (default 16). Period index i gives 2^(BASE_EXP+i) cycles.

Top module: `apb_wdt`

## Requirements
- R1: After reset, all registers read as zero, the counter is disabled, and both `wdt_irq` and `wdt_rst_req` are low.
- R2: The control register at offset 0x00 has bit 0 as the enable and bit 1 as the response mode (0 = reset directly, 1 = interrupt first). A write can set the enable but can never clear it. The mode bit can be written at any time.
- R3: The period register at offset 0x04 holds 8 bits: [3:0] is the normal period index and [7:4] is the initial period index. Written bits above bit 7 are dropped.
- R4: When the enable goes from 0 to 1, the counter loads 2^(BASE_EXP+initial index). While enabled it then decreases by one every clock. Offset 0x08 reads the live counter value, which stays at zero while the block is disabled.
- R5: A write to offset 0x0C whose low byte is 0x76, made while enabled, reloads the counter with 2^(BASE_EXP+normal index) and clears a pending interrupt. Any other value, or any write while disabled, has no effect.
- R6: If the counter is zero during an enabled cycle, the block reloads the normal period and responds. The response therefore becomes visible P+1 cycles after the edge that loaded period P.
- R7: In reset mode, an expiry drives `wdt_rst_req` high for exactly RST_PULSE (default 8) cycles and never raises the interrupt.
- R8: In interrupt mode, the first expiry sets the pending interrupt. A further expiry while the interrupt is still pending produces the reset pulse.
- R9: Offset 0x10 bit 0 reads the pending interrupt. Reading offset 0x14 returns zero, clears the pending interrupt, and leaves the counter running undisturbed.
- R10: Offset 0xF4 is read-only and returns 0x40, with bit 6 showing that the periods are fixed powers of two.
- R11: `pready` is always high. Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| wdt_irq | output | 1 | Pending timeout interrupt |
| wdt_rst_req | output | 1 | System reset request pulse |

## Verification
The assertions check these properties on every cycle:
- the enable never falls;
- the counter is zero while disabled and otherwise falls by exactly one unless a restart intervenes;
- a valid restart lands exactly the selected normal period;
- the interrupt only appears in interrupt mode;
- every reset pulse is exactly RST_PULSE cycles long;
- unmapped reads return zero.

Other behaviour needs the bench's scenarios. These include the P+1 cycle latency from load to response and the escalation from interrupt to reset in interrupt mode. They also include the proof that reading the clear register does not restart the counter and that a restart withdraws a pending interrupt. Each of these depends on a sequence of bus accesses and a measured elapsed time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_RANGE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_KICK   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_PARAMS = 8'hF4;

    localparam logic [7:0]        KICK_CODE  = 8'h76;
    localparam logic [DATA_W-1:0] PARAM_WORD = 32'h0000_0040;

    typedef struct packed {
        logic irq_mode;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] init_idx;
        logic [3:0] norm_idx;
    } range_t;

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a == OFF_CTRL) || (a == OFF_RANGE) || (a == OFF_COUNT) ||
               (a == OFF_KICK) || (a == OFF_ISTAT) || (a == OFF_ICLR)  ||
               (a == OFF_PARAMS);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output ctrl_t             ctrl_o,
    output range_t            range_o,
    output logic              en_rise_o,
    output logic              kick_o,
    output logic              irq_clr_o,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              irq_i
);

    ctrl_t  ctrl_q;
    range_t range_q;
    logic   wr_acc, rd_acc;

    assign wr_acc = psel & penable & pwrite;
    assign rd_acc = psel & penable & ~pwrite;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            range_q <= '0;
        end else if (wr_acc) begin
            if (paddr == OFF_CTRL) begin
                ctrl_q.en       <= ctrl_q.en | pwdata[0];
                ctrl_q.irq_mode <= pwdata[1];
            end
            if (paddr == OFF_RANGE)
                range_q <= range_t'(pwdata[7:0]);
        end
    end

    assign en_rise_o = wr_acc & (paddr == OFF_CTRL) & pwdata[0] & ~ctrl_q.en;
    assign kick_o    = wr_acc & (paddr == OFF_KICK) & (pwdata[7:0] == KICK_CODE) & ctrl_q.en;
    assign irq_clr_o = rd_acc & (paddr == OFF_ICLR);
    assign ctrl_o    = ctrl_q;
    assign range_o   = range_q;

    always_comb begin
        prdata = '0;
        unique case (paddr)
            OFF_CTRL:   prdata = DATA_W'(ctrl_q);
            OFF_RANGE:  prdata = DATA_W'(range_q);
            OFF_COUNT:  prdata = DATA_W'(count_i);
            OFF_ISTAT:  prdata = DATA_W'(irq_i);
            OFF_PARAMS: prdata = PARAM_WORD;
            default:    prdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             en_rise_i,
    input  logic             kick_i,
    input  logic [3:0]       init_idx_i,
    input  logic [3:0]       norm_idx_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] period(input logic [3:0] idx);
        return CNT_W'(1) << (BASE_EXP + int'(idx));
    endfunction

    assign expire_o = en_i & ~kick_i & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en_rise_i)
            cnt_q <= period(init_idx_i);
        else if (en_i) begin
            if (kick_i || cnt_q == '0)
                cnt_q <= period(norm_idx_i);
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp #(
    parameter int RST_PULSE = 8,
    localparam int PW = $clog2(RST_PULSE + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic expire_i,
    input  logic irq_mode_i,
    input  logic kick_i,
    input  logic irq_clr_i,
    output logic irq_o,
    output logic rst_req_o
);

    logic          irq_q;
    logic [PW-1:0] pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            pulse_q <= '0;
        end else begin
            if (pulse_q != '0)
                pulse_q <= pulse_q - 1'b1;
            if (expire_i) begin
                if (irq_mode_i && !irq_q)
                    irq_q <= 1'b1;
                else
                    pulse_q <= PW'(RST_PULSE);
            end else if (kick_i || irq_clr_i) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq_o     = irq_q;
    assign rst_req_o = (pulse_q != '0);

endmodule

// File: rtl/apb_wdt.sv
module apb_wdt
    import wdt_pkg::*;
#(
    parameter int BASE_EXP  = 16,
    parameter int RST_PULSE = 8,
    localparam int CNT_W    = BASE_EXP + 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              wdt_irq,
    output logic              wdt_rst_req
);

    ctrl_t            ctrl;
    range_t           range_q;
    logic             en_rise, kick, irq_clr, expire;
    logic [CNT_W-1:0] count;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .ctrl_o    (ctrl),
        .range_o   (range_q),
        .en_rise_o (en_rise),
        .kick_o    (kick),
        .irq_clr_o (irq_clr),
        .count_i   (count),
        .irq_i     (wdt_irq)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en_i       (ctrl.en),
        .en_rise_i  (en_rise),
        .kick_i     (kick),
        .init_idx_i (range_q.init_idx),
        .norm_idx_i (range_q.norm_idx),
        .count_o    (count),
        .expire_o   (expire)
    );

    wdt_resp #(.RST_PULSE(RST_PULSE)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .expire_i   (expire),
        .irq_mode_i (ctrl.irq_mode),
        .kick_i     (kick),
        .irq_clr_i  (irq_clr),
        .irq_o      (wdt_irq),
        .rst_req_o  (wdt_rst_req)
    );

    assign pready = 1'b1;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int BASE_EXP  = 16,
    parameter int RST_PULSE = 8,
    parameter int CNT_W     = BASE_EXP + 16
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              wdt_irq,
    input logic              wdt_rst_req,
    input logic              en,
    input logic              irq_mode,
    input logic [7:0]        range_bits,
    input logic [CNT_W-1:0]  count
);

    logic       good_kick;
    logic [7:0] hi_len;

    assign good_kick = psel & penable & pwrite & (paddr == OFF_KICK) &
                       (pwdata[7:0] == KICK_CODE) & en;

    always_ff @(posedge clk) begin
        if (rst)              hi_len <= '0;
        else if (wdt_rst_req) hi_len <= hi_len + 1'b1;
        else                  hi_len <= '0;
    end

    // R2
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst) en |=> en);

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !en |-> count == '0);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && count != '0 && !good_kick) |=> count == $past(count) - 1'b1);

    // R5
    kick_reload_chk: assert property (@(posedge clk) disable iff (rst)
        good_kick |=> count == (CNT_W'(1) << (BASE_EXP + int'($past(range_bits[3:0])))));

    // R7
    irq_mode_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> $past(irq_mode));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst_req) |-> hi_len == 8'(RST_PULSE));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && !is_mapped(paddr)) |-> prdata == '0);

endmodule

bind apb_wdt wdt_chk #(.BASE_EXP(BASE_EXP), .RST_PULSE(RST_PULSE), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req),
    .en          (ctrl.en),
    .irq_mode    (ctrl.irq_mode),
    .range_bits  (range_q),
    .count       (count)
);

// File: tb/apb_wdt_tb.sv
`timescale 1ns/1ps
module apb_wdt_tb;

    localparam int BASE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, wdt_irq, wdt_rst_req;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    apb_wdt #(.BASE_EXP(BASE), .RST_PULSE(8)) u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
    );

    // {write, addr, data, expected}
    localparam logic [72:0] VEC [15] = '{
        {1'b0, 8'h00, 32'h0,   32'h0},   // R1
        {1'b0, 8'h04, 32'h0,   32'h0},   // R1
        {1'b0, 8'h08, 32'h0,   32'h0},   // R1
        {1'b0, 8'h10, 32'h0,   32'h0},   // R1
        {1'b0, 8'hF4, 32'h0,   32'h40},  // R10
        {1'b1, 8'h0C, 32'h76,  32'h0},   // R5 kick while disabled
        {1'b0, 8'h08, 32'h0,   32'h0},   // R5
        {1'b1, 8'h04, 32'h321, 32'h0},   // R3
        {1'b0, 8'h04, 32'h0,   32'h21},  // R3
        {1'b1, 8'h20, 32'hFF,  32'h0},   // R11
        {1'b0, 8'h20, 32'h0,   32'h0},   // R11
        {1'b0, 8'h04, 32'h0,   32'h21},  // R11
        {1'b1, 8'h00, 32'h2,   32'h0},   // R2 mode only
        {1'b0, 8'h00, 32'h0,   32'h2},   // R2
        {1'b0, 8'h08, 32'h0,   32'h0}    // R4 idle
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk);
        @(negedge clk);
        penable = 1;
        @(posedge clk);
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1; pwrite = 0; paddr = a;
        @(posedge clk);
        @(negedge clk);
        penable = 1;
        d = prdata;
        @(posedge clk);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    // sel 0: wait for wdt_rst_req, 1: wait for wdt_irq; returns edges taken
    task automatic edges_until(input int sel, output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if ((sel == 0 && wdt_rst_req) || (sel == 1 && wdt_irq)) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n, w;
        do_reset();
        // R1 outputs after reset
        check("R1 irq", {31'b0, wdt_irq}, 0);
        check("R1 rst_req", {31'b0, wdt_rst_req}, 0);
        check("R11 pready", {31'b0, pready}, 1);

        foreach (VEC[i]) begin
            if (VEC[i][72]) apb_wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                apb_rd(VEC[i][71:64], rd);
                check($sformatf("vector %0d (R1-R11 table)", i), rd, VEC[i][31:0]);
            end
        end

        // Reset mode: init idx 1 (32), normal idx 0 (16)
        do_reset();
        apb_wr(8'h04, 32'h10);
        apb_wr(8'h00, 32'h1);                  // R4 load 32
        apb_rd(8'h08, rd); check("R4 initial load", rd, 31);
        apb_wr(8'h00, 32'h0);                  // R2 try to disable
        apb_rd(8'h00, rd); check("R2 enable sticky", rd, 1);
        apb_wr(8'h0C, 32'h55);                 // R5 wrong byte, count 26 -> 24
        apb_rd(8'h08, rd); check("R5 wrong kick ignored", rd, 23);
        apb_wr(8'h0C, 32'h76);                 // R5 reload 16
        edges_until(0, n); check("R6 expiry latency", n, 17);
        check("R7 no irq in reset mode", {31'b0, wdt_irq}, 0);
        w = 1;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); @(negedge clk);
            if (wdt_rst_req) w++; else break;
        end
        check("R7 pulse width", w, 8);

        // Interrupt mode escalation
        do_reset();
        apb_wr(8'h04, 32'h00);
        apb_wr(8'h00, 32'h3);
        edges_until(1, n); check("R8 first expiry irq", n, 17);
        check("R8 no reset on first", {31'b0, wdt_rst_req}, 0);
        apb_rd(8'h10, rd); check("R9 status pending", rd, 1);
        edges_until(0, n); check("R8 second expiry reset", n + 2, 17);

        // Interrupt clear by read
        do_reset();
        apb_wr(8'h04, 32'h00);
        apb_wr(8'h00, 32'h3);
        edges_until(1, n);
        apb_rd(8'h14, rd); check("R9 clear reads zero", rd, 0);
        check("R9 irq cleared", {31'b0, wdt_irq}, 0);
        apb_rd(8'h08, rd); check("R9 no restart on clear", rd, 13);
        edges_until(1, n); check("R9 next expiry irq again", n, 13);
        check("R9 no reset after clear", {31'b0, wdt_rst_req}, 0);

        // Kick clears pending interrupt
        do_reset();
        apb_wr(8'h04, 32'h00);
        apb_wr(8'h00, 32'h3);
        edges_until(1, n);
        apb_wr(8'h0C, 32'hFFFF_FF76);
        check("R5 kick clears irq", {31'b0, wdt_irq}, 0);
        apb_rd(8'h08, rd); check("R5 kick reload", rd, 15);
        edges_until(1, n); check("R5 irq after kick period", n, 15);
        check("R5 no reset after kick", {31'b0, wdt_rst_req}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule